// File: doc/BRIEF.md
# Two-Event Classification Monitor

This block sits on the powered-device side of a Power over Ethernet port and decides whether the power source ran a genuine two-event hardware classification before it applied full power. Each clock it receives one digitized sample of the port voltage, with an LSB of 100 mV. It sorts the sample into a voltage zone: reset band, mark range, lower gap, class window, upper gap or operating range. A zone change counts only if the sample clears the current zone's edge by a hysteresis margin and then stays in the new zone for a set number of consecutive cycles.

A state machine follows the filtered zone through the states IDLE, CLASS1, MARK, CLASS2, ARMED and FLAGGED:

- IDLE to CLASS1 on the first class-window entry.
- CLASS1 to MARK on a mark-range entry.
- MARK to CLASS2 on the second class-window entry.
- CLASS2 to ARMED on reaching the operating range.
- ARMED to FLAGGED when the converter's power-good input is high.
- Back to IDLE from CLASS1, MARK, CLASS2 or ARMED on any reset-band entry.
- Back to IDLE from CLASS1 or MARK on an operating-range entry, because classification was incomplete.
- Back to IDLE from ARMED on leaving the operating range, which is an undervoltage.
- Back to IDLE from FLAGGED on loss of power good or on leaving the operating range.

The active-low output `class2_n` is low only in FLAGGED. System firmware reads it to learn that the higher power level was granted by hardware.

Top module: `twoevent_class_monitor`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `class2_n` is 1 and the machine is in IDLE.
- R2: With the default thresholds, in 100 mV units, the zones are as follows. Reset band is at or below 54. Mark range is 55 to 97. Lower gap is 98 to 129. Class window is 130 to 210 inclusive. Upper gap is 211 to 309. Operating range is 310 and above. A sample of 211 does not count as a class event.
- R3: A new zone is accepted only after the raw zone has held it for DEB_CYCLES consecutive cycles. A departure lasting DEB_CYCLES-1 cycles has no effect on `class2_n`.
- R4: The current zone is kept while the sample lies within HYST codes beyond its edges. For example, in the operating range a sample of 308 keeps the flag, and 306 counts as leaving.
- R5: The sequence class, mark, class, operating range, followed by power good, drives `class2_n` to 0.
- R6: If the port reaches the operating range without any class event, `class2_n` stays 1.
- R7: If the port reaches the operating range after only one class event, `class2_n` stays 1.
- R8: If the reset band is entered during the mark interval, `class2_n` stays 1 even if a class event and power-up follow.
- R9: In ARMED, `class2_n` stays 1 while power good is low. It falls on the first clock edge that samples power good high.
- R10: Loss of power good sets `class2_n` to 1 on the next clock edge and returns the machine to IDLE. Power good returning later does not lower the flag again.
- R11: Leaving the operating range while flagged (undervoltage) releases `class2_n` and returns the machine to IDLE.
- R12: Entering the reset band from CLASS2 returns the machine to IDLE, so a later power-up is not flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_sample | input | VW (10) | Port voltage sample, 100 mV per code |
| pwr_good | input | 1 | Power good from the downstream converter |
| class2_n | output | 1 | Low when a valid two-event classification was seen and power is good |

## Verification
The bench builds the block with its default thresholds, HYST of 3 and DEB_CYCLES of 4. With these values, a glitch of three cycles and a dip of six cycles can be driven side by side to bracket the debounce limit. The samples 308 and 306 fall on opposite sides of the hysteresis margin at the operating edge. Each plateau is held for 12 cycles, well past the debounce and state latency. This lets random walks through the six zones, steered toward the class-mark-class-operate order, reach FLAGGED often while the bench's zone and state functions track every plateau.

// File: rtl/tec_pkg.sv
package tec_pkg;

    // Voltage zones, ordered from lowest to highest port voltage
    typedef enum logic [2:0] {
        ZN_RESET = 3'd0,
        ZN_MARK  = 3'd1,
        ZN_LGAP  = 3'd2,
        ZN_CLASS = 3'd3,
        ZN_MGAP  = 3'd4,
        ZN_OPER  = 3'd5
    } zone_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CLASS1  = 3'd1,
        ST_MARK    = 3'd2,
        ST_CLASS2  = 3'd3,
        ST_ARMED   = 3'd4,
        ST_FLAGGED = 3'd5
    } state_e;

endpackage

// File: rtl/tec_zone_window.sv
module tec_zone_window
    import tec_pkg::*;
#(
    parameter int VW        = 10,
    parameter int RESET_MAX = 54,
    parameter int MARK_MAX  = 97,
    parameter int CLASS_MIN = 130,
    parameter int CLASS_MAX = 210,
    parameter int OPER_MIN  = 310,
    parameter int HYST      = 3
) (
    input  logic [VW-1:0] sample,
    input  zone_e         held,
    output zone_e         raw
);
    localparam int EW = VW + 2;
    localparam logic [EW-1:0] RMAX = EW'(RESET_MAX);
    localparam logic [EW-1:0] MMAX = EW'(MARK_MAX);
    localparam logic [EW-1:0] CMIN = EW'(CLASS_MIN);
    localparam logic [EW-1:0] CMAX = EW'(CLASS_MAX);
    localparam logic [EW-1:0] OMIN = EW'(OPER_MIN);
    localparam logic [EW-1:0] TOP  = EW'((1 << VW) - 1);
    localparam logic [EW-1:0] HW   = EW'(HYST);

    logic [EW-1:0] s_ext;
    zone_e         plain;
    logic [EW-1:0] lo;
    logic [EW-1:0] hi;

    assign s_ext = EW'(sample);

    // Decode without hysteresis
    always_comb begin
        if (s_ext <= RMAX)      plain = ZN_RESET;
        else if (s_ext <= MMAX) plain = ZN_MARK;
        else if (s_ext < CMIN)  plain = ZN_LGAP;
        else if (s_ext <= CMAX) plain = ZN_CLASS;
        else if (s_ext < OMIN)  plain = ZN_MGAP;
        else                    plain = ZN_OPER;
    end

    // Edges of the zone currently held
    always_comb begin
        unique case (held)
            ZN_RESET: begin lo = '0;           hi = RMAX;         end
            ZN_MARK:  begin lo = RMAX + 1'b1;  hi = MMAX;         end
            ZN_LGAP:  begin lo = MMAX + 1'b1;  hi = CMIN - 1'b1;  end
            ZN_CLASS: begin lo = CMIN;         hi = CMAX;         end
            ZN_MGAP:  begin lo = CMAX + 1'b1;  hi = OMIN - 1'b1;  end
            ZN_OPER:  begin lo = OMIN;         hi = TOP;          end
            default:  begin lo = '0;           hi = TOP;          end
        endcase
    end

    generate
        if (HYST == 0) begin : g_no_hyst
            assign raw = plain;
        end else begin : g_hyst
            logic keep;
            assign keep = ((s_ext + HW) >= lo) && (s_ext <= (hi + HW));
            assign raw  = keep ? held : plain;
        end
    endgenerate

endmodule

// File: rtl/tec_zone_filter.sv
module tec_zone_filter
    import tec_pkg::*;
#(
    parameter int DEB_CYCLES = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  zone_e raw,
    output zone_e zone
);
    localparam int            CW    = $clog2(DEB_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DEB_CYCLES);

    zone_e         cand;
    logic [CW-1:0] run;
    logic [CW-1:0] run_nx;

    // Consecutive cycles the raw zone has shown the candidate
    always_comb begin
        run_nx = (raw == cand) ? (run + 1'b1) : CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zone <= ZN_RESET;
            cand <= ZN_RESET;
            run  <= '0;
        end else if (raw == zone) begin
            cand <= zone;
            run  <= '0;
        end else if (run_nx >= LIMIT) begin
            zone <= raw;
            cand <= raw;
            run  <= '0;
        end else begin
            cand <= raw;
            run  <= run_nx;
        end
    end

    // R3
    zone_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(zone) |-> (($past(run) == (LIMIT - 1'b1)) && ($past(raw) == zone)));

endmodule

// File: rtl/tec_seq_fsm.sv
module tec_seq_fsm
    import tec_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  zone_e zone,
    input  logic  pwr_good,
    output logic  class2_n
);
    state_e state;
    state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (zone == ZN_CLASS) state_nx = ST_CLASS1;
            end
            ST_CLASS1: begin
                if (zone == ZN_MARK)                            state_nx = ST_MARK;
                else if (zone == ZN_RESET || zone == ZN_OPER)   state_nx = ST_IDLE;
            end
            ST_MARK: begin
                if (zone == ZN_CLASS)                           state_nx = ST_CLASS2;
                else if (zone == ZN_RESET || zone == ZN_OPER)   state_nx = ST_IDLE;
            end
            ST_CLASS2: begin
                if (zone == ZN_RESET)      state_nx = ST_IDLE;
                else if (zone == ZN_OPER)  state_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (zone != ZN_OPER)       state_nx = ST_IDLE;
                else if (pwr_good)         state_nx = ST_FLAGGED;
            end
            ST_FLAGGED: begin
                if (!pwr_good || zone != ZN_OPER) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Output register, aligned with the state it reports
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) class2_n <= 1'b1;
        else        class2_n <= (state_nx != ST_FLAGGED);
    end

    // R10
    pg_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> class2_n);

    // R9
    flag_needs_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !class2_n |-> $past(pwr_good));

    // R12
    reset_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zone == ZN_RESET) |=> (state == ST_IDLE));

    // R5
    flag_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLAGGED) |-> ($past(state) == ST_ARMED || $past(state) == ST_FLAGGED));

    // R11
    uv_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLAGGED && zone != ZN_OPER) |=> class2_n);

endmodule

// File: rtl/twoevent_class_monitor.sv
module twoevent_class_monitor
    import tec_pkg::*;
#(
    parameter int VW         = 10,
    parameter int RESET_MAX  = 54,
    parameter int MARK_MAX   = 97,
    parameter int CLASS_MIN  = 130,
    parameter int CLASS_MAX  = 210,
    parameter int OPER_MIN   = 310,
    parameter int HYST       = 3,
    parameter int DEB_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] port_sample,
    input  logic          pwr_good,
    output logic          class2_n
);
    zone_e raw_zone;
    zone_e zone;

    tec_zone_window #(
        .VW(VW), .RESET_MAX(RESET_MAX), .MARK_MAX(MARK_MAX),
        .CLASS_MIN(CLASS_MIN), .CLASS_MAX(CLASS_MAX),
        .OPER_MIN(OPER_MIN), .HYST(HYST)
    ) u_window (
        .sample (port_sample),
        .held   (zone),
        .raw    (raw_zone)
    );

    tec_zone_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (raw_zone),
        .zone  (zone)
    );

    tec_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .zone     (zone),
        .pwr_good (pwr_good),
        .class2_n (class2_n)
    );

    // R1
    reset_release_chk: assert property (@(posedge clk)
        !rst_n |=> class2_n);

endmodule

// File: tb/twoevent_class_monitor_tb.sv
module twoevent_class_monitor_tb;
    localparam int VW = 10;
    localparam int RMAX = 54, MMAX = 97, CMIN = 130, CMAX = 210, OMIN = 310;
    localparam int H = 3, DEB = 4;
    localparam int TOPV = (1 << VW) - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [VW-1:0] port_sample;
    logic          pwr_good;
    logic          class2_n;

    int n_chk = 0, n_fail = 0;
    int m_state = 0, m_zone = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    twoevent_class_monitor #(
        .VW(VW), .RESET_MAX(RMAX), .MARK_MAX(MMAX), .CLASS_MIN(CMIN),
        .CLASS_MAX(CMAX), .OPER_MIN(OMIN), .HYST(H), .DEB_CYCLES(DEB)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .port_sample(port_sample),
        .pwr_good(pwr_good), .class2_n(class2_n)
    );

    // Zones: 0 reset, 1 mark, 2 lower gap, 3 class, 4 upper gap, 5 operate
    function automatic int plain_zone(int v);
        if (v <= RMAX) return 0;
        if (v <= MMAX) return 1;
        if (v < CMIN)  return 2;
        if (v <= CMAX) return 3;
        if (v < OMIN)  return 4;
        return 5;
    endfunction

    function automatic int lo_of(int z);
        case (z)
            0: return 0;        1: return RMAX + 1; 2: return MMAX + 1;
            3: return CMIN;     4: return CMAX + 1; default: return OMIN;
        endcase
    endfunction

    function automatic int hi_of(int z);
        case (z)
            0: return RMAX;     1: return MMAX;     2: return CMIN - 1;
            3: return CMAX;     4: return OMIN - 1; default: return TOPV;
        endcase
    endfunction

    function automatic int next_zone(int v, int zp);
        if (v + H >= lo_of(zp) && v <= hi_of(zp) + H) return zp;
        return plain_zone(v);
    endfunction

    // States: 0 idle, 1 class1, 2 mark, 3 class2, 4 armed, 5 flagged
    function automatic int step(int s, int z, bit pg);
        case (s)
            0: return (z == 3) ? 1 : 0;
            1: return (z == 1) ? 2 : ((z == 0 || z == 5) ? 0 : 1);
            2: return (z == 3) ? 3 : ((z == 0 || z == 5) ? 0 : 2);
            3: return (z == 0) ? 0 : ((z == 5) ? 4 : 3);
            4: return (z != 5) ? 0 : (pg ? 5 : 4);
            default: return (!pg || z != 5) ? 0 : 5;
        endcase
    endfunction

    function automatic int settle(int s, int z, bit pg);
        int r = s;
        for (int i = 0; i < 3; i++) r = step(r, z, pg);
        return r;
    endfunction

    function automatic int pick(int z);
        case (z)
            0: return int'($urandom_range(45, 0));
            1: return int'($urandom_range(90, 62));
            2: return int'($urandom_range(122, 105));
            3: return int'($urandom_range(200, 140));
            4: return int'($urandom_range(300, 220));
            default: return int'($urandom_range(600, 320));
        endcase
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: class2_n=%0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic hold(int v, bit pg, int n, string tag, bit do_chk);
        int exp;
        @(negedge clk);
        port_sample = VW'(v);
        pwr_good = pg;
        m_state = settle(m_state, m_zone, pg);
        if (n >= DEB) begin
            m_zone = next_zone(v, m_zone);
            m_state = settle(m_state, m_zone, pg);
        end
        repeat (n - 1) @(negedge clk);
        if (do_chk) begin
            exp = (m_state == 5) ? 0 : 1;
            check(class2_n == exp[0], tag, class2_n, exp);
        end
    endtask

    task automatic reach_flag(string tag);
        hold(30, 0, 12, tag, 1);
        hold(170, 0, 12, tag, 1);
        hold(75, 0, 12, tag, 1);
        hold(170, 0, 12, tag, 1);
        hold(480, 0, 12, tag, 1);
        hold(480, 1, 12, tag, 1);
    endtask

    initial begin
        int pat_idx = 0;
        int pat[4] = '{3, 1, 3, 5};
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        port_sample = '0;
        pwr_good = 1'b0;
        repeat (4) @(negedge clk);
        check(class2_n == 1'b1, "R1 during reset", class2_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(class2_n == 1'b1, "R1 after reset", class2_n, 1);

        // R2 and R5: exact window edges 210, 97, 130, 310
        hold(210, 0, 12, "R2 class upper edge", 1);
        hold(97, 0, 12, "R2 mark upper edge", 1);
        hold(130, 0, 12, "R2 class lower edge", 1);
        hold(310, 0, 12, "R9 armed without power good", 1);
        // R9: falls on the first edge that samples power good
        @(negedge clk);
        pwr_good = 1'b1;
        check(class2_n == 1'b1, "R9 before edge", class2_n, 1);
        @(negedge clk);
        check(class2_n == 1'b0, "R9 one edge later", class2_n, 0);
        m_state = settle(m_state, m_zone, 1'b1);
        hold(310, 1, 12, "R5 flagged", 1);

        // R10
        @(negedge clk);
        pwr_good = 1'b0;
        @(negedge clk);
        check(class2_n == 1'b1, "R10 release next edge", class2_n, 1);
        m_state = settle(m_state, m_zone, 1'b0);
        hold(480, 1, 12, "R10 no re-flag", 1);

        // R3: glitch of DEB-1 ignored, DEB+2 accepted
        reach_flag("R5 full sequence");
        hold(30, 1, DEB - 1, "R3 glitch", 0);
        hold(480, 1, 12, "R3 short glitch ignored", 1);
        hold(30, 1, DEB + 2, "R3 long dip", 0);
        hold(480, 1, 12, "R3 long dip accepted", 1);

        // R4 and R11
        reach_flag("R5 full sequence");
        hold(308, 1, 12, "R4 inside hysteresis", 1);
        hold(306, 1, 12, "R4 beyond hysteresis", 1);
        reach_flag("R5 full sequence");
        hold(250, 1, 12, "R11 undervoltage", 1);

        // R6
        hold(30, 0, 12, "R6 setup", 1);
        hold(480, 1, 12, "R6 skipped classification", 1);
        // R7
        hold(30, 0, 12, "R7 setup", 1);
        hold(170, 0, 12, "R7 one event", 1);
        hold(480, 1, 12, "R7 one event power-up", 1);
        // R2: 211 is not a class event
        hold(0, 0, 12, "R2 setup", 1);
        hold(211, 0, 12, "R2 just above class", 1);
        hold(97, 0, 12, "R2 mark", 1);
        hold(130, 0, 12, "R2 class", 1);
        hold(310, 1, 12, "R2 211 not counted", 1);
        // R8
        hold(30, 0, 12, "R8 setup", 1);
        hold(170, 0, 12, "R8 first event", 1);
        hold(75, 0, 12, "R8 mark", 1);
        hold(40, 0, 12, "R8 reset in mark", 1);
        hold(170, 0, 12, "R8 second event", 1);
        hold(480, 1, 12, "R8 power-up", 1);
        // R12
        hold(30, 0, 12, "R12 setup", 1);
        hold(170, 0, 12, "R12 first event", 1);
        hold(75, 0, 12, "R12 mark", 1);
        hold(170, 0, 12, "R12 second event", 1);
        hold(30, 0, 12, "R12 reset from class2", 1);
        hold(480, 1, 12, "R12 power-up", 1);

        // Random plateaus steered toward the valid order
        for (int i = 0; i < 300; i++) begin
            int z;
            bit pg;
            if ($urandom_range(3, 0) != 0) begin
                z = pat[pat_idx % 4];
                pat_idx++;
            end else begin
                z = int'($urandom_range(5, 0));
            end
            pg = ($urandom_range(2, 0) != 0);
            hold(pick(z), pg, 12, "R5 random plateau", 1);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        done = 1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not end, actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule